// File: doc/BRIEF.md
# Framed packet receiver with CRC check

This block sits behind a UART receiver and turns its byte stream into checked packets. It searches the stream for the two-byte start pattern 0xAA then 0x55, then collects a frame-kind byte, a 16-bit length sent high byte first, the payload, a 16-bit check value sent high byte first, and a closing byte that must be 0xFF.

While the frame arrives it keeps a running CRC16-CCITT over the frame-kind byte, both length bytes and the payload. The CRC uses polynomial 0x1021, starts at 0xFFFF, has no bit reflection and no final XOR. The start pattern and the closing byte are not part of the CRC. Payload bytes are forwarded at once on a valid/last stream. When the closing byte arrives, the block gives a one-cycle verdict strobe. The acknowledge strobe asks the link layer to send a positive reply. The reject strobe asks for a negative reply. A consumer that buffers the payload commits or discards it on that verdict.

A length above `MAX_LEN` drops the frame without any verdict. So does a gap of `TIMEOUT` idle cycles in the middle of a frame. In both cases the block goes back to searching.

The states are:
- HUNT: wait for 0xAA.
- SYNC2: expect 0x55. A second 0xAA stays in SYNC2. Any other byte returns to HUNT.
- TYPE, LEN_HI, LEN_LO: header bytes. LEN_LO goes to PAY, to CRC_HI when the length is zero, or to HUNT when the length is too large.
- PAY: payload bytes. After the last one it moves to CRC_HI.
- CRC_HI, CRC_LO: the received check value.
- DELIM: the closing byte, which produces the verdict and returns to HUNT.

The timeout moves any state other than HUNT back to HUNT.

Top module: `frame_rx`

## Requirements
- R1: After reset `out_valid`, `out_last`, `ack_req` and `nack_req` are low and the receiver is searching for a start pattern.
- R2: A frame begins only on 0xAA immediately followed by 0x55. Other bytes while searching produce nothing. A byte other than 0x55 or 0xAA after 0xAA restarts the search. A repeated 0xAA counts as a fresh first start byte, so AA AA 55 starts a frame.
- R3: Each payload byte appears on `out_data` with `out_valid` high exactly one cycle after it is accepted, in arrival order. `out_last` is high with the final payload byte only. `out_valid` is never high outside payload.
- R4: `frame_type` holds the frame-kind byte (the byte right after 0x55) of the current frame while its verdict strobe is high.
- R5: If the closing byte is 0xFF and the received CRC (high byte first) equals the CRC computed over the kind byte, the length bytes and the payload, `ack_req` pulses for exactly one cycle, one cycle after the closing byte is accepted.
- R6: A frame whose received CRC differs from the computed one gives a one-cycle `nack_req` pulse one cycle after the closing byte is accepted, and no `ack_req`.
- R7: A closing byte other than 0xFF gives `nack_req` and no `ack_req`, even when the CRC matches.
- R8: A zero-length frame has no payload output and is judged on the CRC over the kind byte and the two length bytes alone.
- R9: A length equal to `MAX_LEN` is accepted. A length above `MAX_LEN` abandons the frame with no verdict and no payload output, and the following bytes are searched for a new start pattern.
- R10: After `TIMEOUT` consecutive cycles with `in_valid` low in the middle of a frame, the receiver drops the frame with no verdict and returns to searching. A gap of `TIMEOUT`-1 cycles leaves the frame intact.
- R11: `ack_req` and `nack_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_byte` this cycle |
| in_byte | input | 8 | Received byte from the UART |
| out_valid | output | 1 | Payload byte valid on `out_data` |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Marks the final payload byte of a frame |
| ack_req | output | 1 | One-cycle request for a positive reply |
| nack_req | output | 1 | One-cycle request for a negative reply |
| frame_type | output | 8 | Frame-kind byte of the current frame |

## Verification
Every result is registered once. A payload byte shows on the stream, and a closing byte produces its verdict, in the cycle after the clock edge that accepted the input. A timeout takes effect on the edge that ends the `TIMEOUT`-th idle cycle.

The bench drives inputs on falling edges and samples outputs on falling edges. It also delays its own "this byte is payload" flag by one rising edge and compares it with `out_valid` in every cycle, so an early or late byte is reported even when the byte count is right. Verdict and stream counts are read three idle cycles after each frame ends, when every pulse has already fired.

// File: rtl/frx_pkg.sv
package frx_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_SYNC2,
        ST_TYPE,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_PAY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_DELIM
    } frx_state_e;

    localparam logic [7:0]  FRX_SYNC_A   = 8'hAA;
    localparam logic [7:0]  FRX_SYNC_B   = 8'h55;
    localparam logic [7:0]  FRX_END      = 8'hFF;
    localparam logic [15:0] FRX_POLY     = 16'h1021;
    localparam logic [15:0] FRX_CRC_INIT = 16'hFFFF;

endpackage

// File: rtl/frx_crc_step.sv
// One byte of a non-reflected CRC, most significant bit first.
module frx_crc_step #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = W'(16'h1021)
) (
    input  logic [W-1:0] crc_in,
    input  logic [7:0]   data,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] acc;
    logic         fb;

    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            fb  = acc[W-1] ^ data[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/frx_gap_timer.sv
// Counts idle cycles while armed; fires on the LIMIT-th consecutive one.
module frx_gap_timer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic activity,
    output logic fire
);
    localparam int TW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    assign fire = armed && !activity && (cnt_q == TW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!armed || activity || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import frx_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int TIMEOUT = 40,
    parameter int LEN_W   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       ack_req,
    output logic       nack_req,
    output logic [7:0] frame_type
);
    localparam int CW = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN + 1);

    frx_state_e state_q, state_d;

    logic [7:0]       len_hi_q;
    logic [7:0]       crc_hi_q;
    logic [7:0]       type_q;
    logic [15:0]      crc_q;
    logic [15:0]      crc_seed;
    logic [15:0]      crc_next;
    logic [CW-1:0]    rem_q;
    logic             crc_ok_q;
    logic             tmo_fire;
    logic [LEN_W-1:0] len_full;
    logic             too_long;
    logic             is_last_pay;
    logic             good_end;

    assign len_full    = {len_hi_q, in_byte};
    assign too_long    = len_full > LEN_W'(MAX_LEN);
    assign is_last_pay = (rem_q == CW'(1));
    assign good_end    = (in_byte == FRX_END) && crc_ok_q;
    assign crc_seed    = (state_q == ST_TYPE) ? FRX_CRC_INIT : crc_q;
    assign frame_type  = type_q;

    frx_crc_step #(
        .W    (16),
        .POLY (FRX_POLY)
    ) u_crc (
        .crc_in  (crc_seed),
        .data    (in_byte),
        .crc_out (crc_next)
    );

    frx_gap_timer #(
        .LIMIT (TIMEOUT)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (state_q != ST_HUNT),
        .activity (in_valid),
        .fire     (tmo_fire)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (tmo_fire) begin
            state_d = ST_HUNT;
        end else if (in_valid) begin
            unique case (state_q)
                ST_HUNT:   if (in_byte == FRX_SYNC_A) state_d = ST_SYNC2;
                ST_SYNC2: begin
                    if (in_byte == FRX_SYNC_B)      state_d = ST_TYPE;
                    else if (in_byte == FRX_SYNC_A) state_d = ST_SYNC2;
                    else                            state_d = ST_HUNT;
                end
                ST_TYPE:   state_d = ST_LEN_HI;
                ST_LEN_HI: state_d = ST_LEN_LO;
                ST_LEN_LO: begin
                    if (too_long)                 state_d = ST_HUNT;
                    else if (len_full == '0)      state_d = ST_CRC_HI;
                    else                          state_d = ST_PAY;
                end
                ST_PAY:    if (is_last_pay) state_d = ST_CRC_HI;
                ST_CRC_HI: state_d = ST_CRC_LO;
                ST_CRC_LO: state_d = ST_DELIM;
                ST_DELIM:  state_d = ST_HUNT;
                default:   state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Header, CRC and length datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_hi_q <= '0;
            crc_hi_q <= '0;
            type_q   <= '0;
            crc_q    <= FRX_CRC_INIT;
            rem_q    <= '0;
            crc_ok_q <= 1'b0;
        end else if (in_valid) begin
            unique case (state_q)
                ST_TYPE: begin
                    type_q <= in_byte;
                    crc_q  <= crc_next;
                end
                ST_LEN_HI: begin
                    len_hi_q <= in_byte;
                    crc_q    <= crc_next;
                end
                ST_LEN_LO: begin
                    rem_q <= len_full[CW-1:0];
                    crc_q <= crc_next;
                end
                ST_PAY: begin
                    rem_q <= rem_q - CW'(1);
                    crc_q <= crc_next;
                end
                ST_CRC_HI: crc_hi_q <= in_byte;
                ST_CRC_LO: crc_ok_q <= ({crc_hi_q, in_byte} == crc_q);
                default: ;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            ack_req   <= 1'b0;
            nack_req  <= 1'b0;
        end else begin
            out_valid <= in_valid && (state_q == ST_PAY);
            out_last  <= in_valid && (state_q == ST_PAY) && is_last_pay;
            ack_req   <= in_valid && (state_q == ST_DELIM) && good_end;
            nack_req  <= in_valid && (state_q == ST_DELIM) && !good_end;
            if (in_valid && (state_q == ST_PAY)) begin
                out_data <= in_byte;
            end
        end
    end
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk
    import frx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       out_last,
    input logic       ack_req,
    input logic       nack_req,
    input frx_state_e state_q,
    input logic       tmo_fire
);
    p_verdict_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_req && nack_req));

    p_last_in_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_stream_from_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state_q) == ST_PAY) && $past(in_valid));

    p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);

    p_nack_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |=> !nack_req);

    p_verdict_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req || nack_req) |-> ($past(state_q) == ST_DELIM) && $past(in_valid));

    p_stall_to_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (state_q == ST_HUNT));
endmodule

bind frame_rx frame_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_last  (out_last),
    .ack_req   (ack_req),
    .nack_req  (nack_req),
    .state_q   (state_q),
    .tmo_fire  (tmo_fire)
);

// File: tb/frame_rx_tb.sv
`timescale 1ns/1ps
module frame_rx_tb;
    localparam int MAXL = 64;
    localparam int TMO  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       out_valid, out_last, ack_req, nack_req;
    logic [7:0] out_data, frame_type;

    always #2 clk = ~clk;

    frame_rx #(.MAX_LEN(MAXL), .TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .ack_req(ack_req), .nack_req(nack_req), .frame_type(frame_type)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Monitor state
    logic       pay_flag = 1'b0;
    logic       pay_d    = 1'b0;
    int         ack_n, nack_n, vcount, last_n, last_idx, mism;
    logic [7:0] typ_seen;
    logic [7:0] rxbuf [0:127];

    always @(posedge clk) pay_d <= in_valid && pay_flag;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (vcount < 128) rxbuf[vcount] = out_data;
                if (out_last) begin last_idx = vcount; last_n++; end
                vcount++;
            end
            if (ack_req)  begin ack_n++;  typ_seen = frame_type; end
            if (nack_req) begin nack_n++; typ_seen = frame_type; end
            if (out_valid !== pay_d) mism++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ack_n = 0; nack_n = 0; vcount = 0; last_n = 0; last_idx = -1; mism = 0;
        typ_seen = '0;
    endtask

    task automatic put(input logic [7:0] b, input logic is_pay);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; pay_flag = is_pay;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; pay_flag = 1'b0;
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] pbyte(input int seed, input int i);
        return 8'((seed + 3 * i) & 8'h7F);
    endfunction

    // stall_at: byte index (0 = first sync) before which stall_n idle cycles are
    // inserted; a stall of TMO or more makes every later byte non-payload.
    task automatic send_frame(input logic [7:0] typ, input int len, input int seed,
                              input logic [15:0] crc_flip, input logic [7:0] endb,
                              input int stall_at, input int stall_n);
        logic [15:0] c;
        logic [7:0]  seq [0:127];
        int          n;
        bit          dead;
        c = 16'hFFFF;
        c = crc_add(c, typ);
        c = crc_add(c, 8'(len >> 8));
        c = crc_add(c, 8'(len));
        for (int i = 0; i < len; i++) c = crc_add(c, pbyte(seed, i));
        c = c ^ crc_flip;
        seq[0] = 8'hAA; seq[1] = 8'h55; seq[2] = typ;
        seq[3] = 8'(len >> 8); seq[4] = 8'(len);
        for (int i = 0; i < len; i++) seq[5 + i] = pbyte(seed, i);
        n = 5 + len;
        seq[n] = c[15:8]; seq[n + 1] = c[7:0]; seq[n + 2] = endb;
        n = n + 3;
        dead = 0;
        for (int i = 0; i < n; i++) begin
            if (i == stall_at && stall_n > 0) begin
                idle(stall_n);
                if (stall_n >= TMO) dead = 1;
            end
            put(seq[i], !dead && i >= 5 && i < 5 + len);
        end
        idle(3);
    endtask

    task automatic check_payload(input string req, input int len, input int seed);
        int bad = 0;
        for (int i = 0; i < len && i < 128; i++)
            if (rxbuf[i] !== pbyte(seed, i)) bad++;
        chk({req, " payload bytes mismatched"}, bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 ack_req after reset",   int'(ack_req), 0);
        chk("R1 nack_req after reset",  int'(nack_req), 0);
        chk("R1 out_last after reset",  int'(out_last), 0);
    endtask

    task automatic t_good();
        clear_mon();
        send_frame(8'h01, 5, 17, 16'h0, 8'hFF, -1, 0);
        chk("R5 ack count", ack_n, 1);
        chk("R5 nack count", nack_n, 0);
        chk("R3 byte count", vcount, 5);
        check_payload("R3", 5, 17);
        chk("R3 last index", last_idx, 4);
        chk("R3 last count", last_n, 1);
        chk("R3 stream timing mismatches", mism, 0);
        chk("R4 frame_type at verdict", int'(typ_seen), 8'h01);
    endtask

    task automatic t_bad_crc();
        clear_mon();
        send_frame(8'h02, 4, 40, 16'h0100, 8'hFF, -1, 0);
        chk("R6 nack count", nack_n, 1);
        chk("R6 ack count", ack_n, 0);
        chk("R11 stream timing mismatches", mism, 0);
        chk("R4 frame_type on nack", int'(typ_seen), 8'h02);
    endtask

    task automatic t_bad_end();
        clear_mon();
        send_frame(8'h03, 3, 9, 16'h0, 8'hFE, -1, 0);
        chk("R7 nack count", nack_n, 1);
        chk("R7 ack count", ack_n, 0);
    endtask

    task automatic t_zero_len();
        clear_mon();
        send_frame(8'h04, 0, 0, 16'h0, 8'hFF, -1, 0);
        chk("R8 ack count", ack_n, 1);
        chk("R8 payload count", vcount, 0);
        clear_mon();
        send_frame(8'h04, 0, 0, 16'h0001, 8'hFF, -1, 0);
        chk("R8 nack on bad crc", nack_n, 1);
    endtask

    task automatic t_sync();
        clear_mon();
        put(8'h55, 0); put(8'h00, 0); put(8'hAA, 0); put(8'h13, 0); put(8'h55, 0);
        idle(3);
        chk("R2 no output from noise", vcount + ack_n + nack_n, 0);
        clear_mon();
        put(8'hAA, 0);
        send_frame(8'h01, 2, 60, 16'h0, 8'hFF, -1, 0);
        chk("R2 AA AA 55 accepted", ack_n, 1);
        chk("R2 payload after repeated sync", vcount, 2);
        chk("R2 stream timing mismatches", mism, 0);
    endtask

    task automatic t_max_len();
        clear_mon();
        send_frame(8'h02, MAXL, 5, 16'h0, 8'hFF, -1, 0);
        chk("R9 ack at MAX_LEN", ack_n, 1);
        chk("R9 bytes at MAX_LEN", vcount, MAXL);
        check_payload("R9", MAXL, 5);
        clear_mon();
        put(8'hAA, 0); put(8'h55, 0); put(8'h01, 0);
        put(8'((MAXL + 1) >> 8), 0); put(8'(MAXL + 1), 0);
        put(8'h11, 0); put(8'h22, 0); put(8'h33, 0); put(8'hFF, 0);
        idle(3);
        chk("R9 oversize no verdict", ack_n + nack_n, 0);
        chk("R9 oversize no payload", vcount, 0);
        send_frame(8'h03, 1, 1, 16'h0, 8'hFF, -1, 0);
        chk("R9 resync after abort", ack_n, 1);
        chk("R9 stream timing mismatches", mism, 0);
    endtask

    task automatic t_timeout();
        clear_mon();
        send_frame(8'h01, 3, 20, 16'h0, 8'hFF, 6, TMO - 1);
        chk("R10 gap of TIMEOUT-1 keeps frame", ack_n, 1);
        chk("R10 bytes kept", vcount, 3);
        clear_mon();
        send_frame(8'h01, 3, 20, 16'h0, 8'hFF, 6, TMO);
        chk("R10 stalled frame no verdict", ack_n + nack_n, 0);
        chk("R10 stalled frame bytes", vcount, 1);
        send_frame(8'h02, 2, 30, 16'h0, 8'hFF, -1, 0);
        chk("R10 next frame accepted", ack_n, 1);
        chk("R10 stream timing mismatches", mism, 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_bad_crc();
        t_bad_end();
        t_zero_len();
        t_sync();
        t_max_len();
        t_timeout();
        finish_up();
    end
endmodule